// File: doc/BRIEF.md
# Byte-Serial SPI Master with Length-Steered Inter-Byte Pause

This block is a byte-wide SPI master that runs in mode 0. SCLK idles low. MOSI moves while SCLK is low and MISO is captured on each rising edge. A four-entry transmit queue feeds the byte shifter, and received bytes land in a four-entry receive queue. Both queues face the rest of the chip through valid/ready handshakes. The transmit side accepts a byte only in a cycle where `tx_valid` and `tx_ready` are both high, and `tx_ready` falls while the queue is full. The receive side holds `rx_valid` and `rx_data` steady until `rx_ready` takes the byte. The SCLK half-period is a programmable count of system clocks.

A transfer begins when `cfg_enable` rises and keeps chip select low until it ends. In polled mode the transfer ends when `cfg_enable` is dropped. In counted (DMA) mode a byte-count register drops by one after each byte, and the transfer completes by itself when the count reaches zero. The same count also decides the spacing between bytes, in both modes. When it reads 0 or 1 once a byte has finished, SCLK stays low for one extra full SCLK period before the next byte. At 2 or above the bytes run back to back. In polled mode the count is otherwise unused.

Top module: `spi_gap_master`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, `xfer_done` is 0, `len_count` is 0, `rx_valid` is 0 and `tx_ready` is 1.
- R2: Each byte is framed by exactly eight SCLK rising edges, most significant bit first. MOSI holds steady while SCLK is high, so the value seen at each rising edge is the data bit.
- R3: Each SCLK half-period lasts `cfg_div` system clocks, and a value of 0 gives 2^DIV_W clocks (256 by default). Within a byte, consecutive rising edges are 2*half apart.
- R4: If the count reads 0 or 1 when a byte finishes and another byte follows, the next rising edge comes 4*half clocks after the previous one. This holds in both modes.
- R5: If the count reads 2 or more when a byte finishes, the next byte's first rising edge comes 2*half clocks after the previous rising edge, with no pause.
- R6: In DMA mode `len_count` drops by exactly one per byte. When it reaches zero, `xfer_done` rises and `spi_cs_n` returns high. Enabling DMA mode with a count of 0 completes with no SCLK edges.
- R7: In polled mode `len_count` never changes except through a write.
- R8: A count write (`cfg_len_wr`) takes effect only while no transfer is active. While chip select is low, the write is ignored.
- R9: `tx_ready` is 0 while the four-entry transmit queue is full. When the queue runs dry mid-transfer, SCLK stays low and `spi_cs_n` stays 0 until data arrives.
- R10: Each captured byte enters the receive queue after its eighth rising edge, and the bytes come out in order. While that queue is full, no new byte starts. `rx_valid`/`rx_data` hold until accepted.
- R11: SCLK is low whenever `spi_cs_n` is high. Dropping `cfg_enable` between bytes in polled mode releases `spi_cs_n`.
- R12: Bytes sent in DMA mode and then in polled mode on the same instance all arrive intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Start or hold a transfer |
| cfg_dma_en | input | 1 | 1 = counted (DMA) mode, 0 = polled mode |
| cfg_len_wr | input | 1 | Write strobe for the byte count |
| cfg_len_wdata | input | LEN_W | Byte count value to write |
| cfg_div | input | DIV_W | SCLK half-period in system clocks, 0 = 2^DIV_W |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit queue can accept |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Oldest received byte |
| rx_ready | input | 1 | Consumer takes the received byte |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |
| len_count | output | LEN_W | Live byte count |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | Counted transfer completed |

## Verification
A bad shifter or bit counter shows up as a byte with the wrong value or the wrong number of rising edges. The bench sees this at MOSI and in the looped-back receive data within one byte time. A wrong gap decision or a stale count moves the next rising edge by exactly two half-periods at the first byte boundary, so the bench measures rising-edge spacing in system clocks. A count that is not decremented, or a done state that is never reached, leaves `len_count`, `xfer_done` and `spi_cs_n` wrong a few half-periods after the last byte. A missed stall on a full receive queue shows up as extra SCLK edges or lost bytes.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SHIFT,
    ST_GAP,
    ST_DONE
  } spi_state_e;

  // A pause of one SCLK period follows a byte when the count it leaves is 0 or 1.
  function automatic logic gap_needed(input logic [31:0] count_after);
    return count_after <= 32'd1;
  endfunction

endpackage

// File: rtl/spi_gap_fifo.sv
module spi_gap_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;
  logic             do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      unique case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_gap_clkdiv.sv
module spi_gap_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W:0] MAX_DIV = (DIV_W+1)'(1) << DIV_W;

  logic [DIV_W:0] limit;
  logic [DIV_W:0] cnt;

  assign limit = (div == '0) ? MAX_DIV : {1'b0, div};
  assign tick  = run && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_gap_engine.sv
module spi_gap_engine
  import spi_gap_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             dma_en,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_wdata,
  input  logic             tick,
  output logic             run,
  input  logic             tx_avail,
  input  logic [7:0]       tx_byte,
  output logic             tx_pop,
  input  logic             rx_room,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n,
  output logic [LEN_W-1:0] len_q,
  output logic             done
);
  spi_state_e state;
  logic [7:0] sh_tx, sh_rx;
  logic [2:0] bit_idx;
  logic       gap_half;
  logic       sclk_q;

  logic             can_start, byte_end, ends_now, pause_now;
  logic             load_wait, load_end, load_gap, load_now;
  logic [LEN_W-1:0] len_next;

  assign can_start = enable && tx_avail && rx_room;
  assign byte_end  = (state == ST_SHIFT) && tick && sclk_q && (bit_idx == 3'd7);
  assign len_next  = (dma_en && len_q != '0) ? len_q - LEN_W'(1) : len_q;
  assign ends_now  = dma_en && (len_next == '0);
  assign pause_now = gap_needed(32'(len_next));

  assign load_wait = (state == ST_WAIT) && enable && !(dma_en && len_q == '0)
                     && tx_avail && rx_room;
  assign load_end  = byte_end && !ends_now && !pause_now && can_start;
  assign load_gap  = (state == ST_GAP) && tick && gap_half && can_start;
  assign load_now  = load_wait || load_end || load_gap;
  assign tx_pop    = load_now;

  assign rx_push = (state == ST_SHIFT) && tick && !sclk_q && (bit_idx == 3'd7);
  assign rx_byte = {sh_rx[6:0], miso};

  assign run  = (state == ST_SHIFT) || (state == ST_GAP);
  assign sclk = sclk_q;
  assign mosi = (state == ST_SHIFT) ? sh_tx[7] : 1'b0;
  assign cs_n = (state == ST_IDLE) || (state == ST_DONE);
  assign done = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sclk_q   <= 1'b0;
      sh_tx    <= '0;
      sh_rx    <= '0;
      bit_idx  <= '0;
      gap_half <= 1'b0;
      len_q    <= '0;
    end else begin
      if (len_wr && (state == ST_IDLE || state == ST_DONE)) len_q <= len_wdata;
      if (byte_end) len_q <= len_next;
      if (load_now) begin
        sh_tx   <= tx_byte;
        bit_idx <= '0;
      end
      unique case (state)
        ST_IDLE: if (enable) state <= ST_WAIT;
        ST_WAIT: begin
          if (!enable)                     state <= ST_IDLE;
          else if (dma_en && len_q == '0)  state <= ST_DONE;
          else if (load_now)               state <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            sh_rx  <= {sh_rx[6:0], miso};
          end else begin
            sclk_q <= 1'b0;
            if (bit_idx != 3'd7) begin
              sh_tx   <= {sh_tx[6:0], 1'b0};
              bit_idx <= bit_idx + 1'b1;
            end else if (ends_now) begin
              state <= ST_DONE;
            end else if (pause_now) begin
              state    <= ST_GAP;
              gap_half <= 1'b0;
            end else if (!load_now) begin
              state <= ST_WAIT;
            end
          end
        end
        ST_GAP: if (tick) begin
          if (!gap_half) gap_half <= 1'b1;
          else           state <= load_now ? ST_SHIFT : ST_WAIT;
        end
        ST_DONE: if (!enable) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_gap_master.sv
module spi_gap_master #(
  parameter int LEN_W    = 16,
  parameter int DIV_W    = 8,
  parameter int Q_DEPTH  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_dma_en,
  input  logic             cfg_len_wr,
  input  logic [LEN_W-1:0] cfg_len_wdata,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  input  logic             rx_ready,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_cs_n,
  output logic [LEN_W-1:0] len_count,
  output logic             xfer_busy,
  output logic             xfer_done
);
  logic       tx_full, tx_empty, tx_pop;
  logic [7:0] tx_head;
  logic       rx_full, rx_empty, rx_push;
  logic [7:0] rx_byte;
  logic       run, tick;

  assign tx_ready  = !tx_full;
  assign rx_valid  = !rx_empty;
  assign xfer_busy = !spi_cs_n;

  spi_gap_fifo #(.WIDTH(8), .DEPTH(Q_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_valid), .wdata(tx_data), .pop(tx_pop),
    .rdata(tx_head), .full(tx_full), .empty(tx_empty)
  );

  spi_gap_fifo #(.WIDTH(8), .DEPTH(Q_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .wdata(rx_byte), .pop(rx_ready),
    .rdata(rx_data), .full(rx_full), .empty(rx_empty)
  );

  spi_gap_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .div(cfg_div), .tick(tick)
  );

  spi_gap_engine #(.LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .enable(cfg_enable), .dma_en(cfg_dma_en),
    .len_wr(cfg_len_wr), .len_wdata(cfg_len_wdata),
    .tick(tick), .run(run),
    .tx_avail(!tx_empty), .tx_byte(tx_head), .tx_pop(tx_pop),
    .rx_room(!rx_full), .rx_push(rx_push), .rx_byte(rx_byte),
    .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso),
    .cs_n(spi_cs_n), .len_q(len_count), .done(xfer_done)
  );
endmodule

// File: rtl/spi_gap_master_chk.sv
module spi_gap_master_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_dma_en,
  input logic             cfg_len_wr,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [7:0]       rx_data,
  input logic             spi_sclk,
  input logic             spi_mosi,
  input logic             spi_cs_n,
  input logic             xfer_done,
  input logic [LEN_W-1:0] len_count
);
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R2

  AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R11

  AST_DONE_RELEASES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> spi_cs_n); // R6

  AST_COUNT_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_len_wr) |-> (len_count == $past(len_count) ||
                            len_count == $past(len_count) - LEN_W'(1))); // R6

  AST_POLLED_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cfg_dma_en) && $past(!cfg_len_wr)) |-> $stable(len_count)); // R7

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R10
endmodule

bind spi_gap_master spi_gap_master_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_dma_en(cfg_dma_en), .cfg_len_wr(cfg_len_wr),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
  .xfer_done(xfer_done), .len_count(len_count)
);

// File: tb/tb_spi_gap_master.sv
`timescale 1ns/1ps
module tb_spi_gap_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0, cfg_dma_en = 1'b0, cfg_len_wr = 1'b0;
  logic [15:0] cfg_len_wdata = '0;
  logic [7:0]  cfg_div = 8'd2;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_ready, rx_valid, rx_ready = 1'b0;
  logic [7:0]  rx_data;
  logic        spi_sclk, spi_mosi, spi_cs_n, xfer_busy, xfer_done;
  logic [15:0] len_count;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spi_gap_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_dma_en(cfg_dma_en),
    .cfg_len_wr(cfg_len_wr), .cfg_len_wdata(cfg_len_wdata), .cfg_div(cfg_div),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_mosi),
    .spi_cs_n(spi_cs_n), .len_count(len_count), .xfer_busy(xfer_busy),
    .xfer_done(xfer_done)
  );

  // Rising-edge monitor: cycle stamp and MOSI value of every SCLK rise.
  int   cyc = 0;
  int   rise_total = 0;
  int   stamp [1024];
  logic bitv [1024];
  logic sclk_d = 1'b0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && spi_sclk && !sclk_d && rise_total < 1024) begin
      stamp[rise_total] = cyc;
      bitv[rise_total]  = spi_mosi;
      rise_total = rise_total + 1;
    end
    sclk_d = spi_sclk;
  end

  typedef struct packed {
    logic        dma;
    logic [15:0] len;
    logic [7:0]  div;
    logic [15:0] gap1;
    logic [15:0] gap2;
    logic [15:0] fin_len;
    logic        fin_done;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 16'd0, 8'd2, 16'd8,  16'd8,  16'd0, 1'b0},
    '{1'b0, 16'd1, 8'd3, 16'd12, 16'd12, 16'd1, 1'b0},
    '{1'b0, 16'd2, 8'd2, 16'd4,  16'd4,  16'd2, 1'b0},
    '{1'b1, 16'd3, 8'd2, 16'd4,  16'd8,  16'd0, 1'b1},
    '{1'b0, 16'd9, 8'd1, 16'd2,  16'd2,  16'd9, 1'b0},
    '{1'b1, 16'd5, 8'd2, 16'd4,  16'd4,  16'd2, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_rx(input logic [7:0] exp, input string req);
    @(negedge clk);
    check(req, "rx_valid", 32'(rx_valid), 32'd1);
    check(req, "rx_data", 32'(rx_data), 32'(exp));
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic write_len(input logic [15:0] v);
    @(negedge clk);
    cfg_len_wr = 1'b1; cfg_len_wdata = v;
    @(negedge clk);
    cfg_len_wr = 1'b0;
  endtask

  task automatic wait_rises(input int target);
    while (rise_total < target) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "cs_n", 32'(spi_cs_n), 32'd1);
    check("R1", "sclk", 32'(spi_sclk), 32'd0);
    check("R1", "done", 32'(xfer_done), 32'd0);
    check("R1", "len", 32'(len_count), 32'd0);
    check("R1", "rx_valid", 32'(rx_valid), 32'd0);
    check("R1", "tx_ready", 32'(tx_ready), 32'd1);

    // Vector table: three bytes per row, gaps R4/R5, count R6/R7, mixing R12.
    for (int v = 0; v < NVEC; v++) begin
      vec_t tv;
      int   base;
      logic [7:0] sent [3];
      logic [7:0] seen;
      tv = VECS[v];
      cfg_dma_en = tv.dma;
      cfg_div    = tv.div;
      write_len(tv.len);
      base = rise_total;
      for (int k = 0; k < 3; k++) begin
        sent[k] = 8'(8'h3C + v * 29 + k * 71);
        push_tx(sent[k]);
      end
      @(negedge clk);
      cfg_enable = 1'b1;
      wait_rises(base + 24);
      repeat (4 * int'(tv.div) + 20) @(negedge clk);
      check(tv.gap1 > 16'd4 * tv.div ? "R4" : "R5", "gap after byte 1",
            32'(stamp[base + 8] - stamp[base + 7]), 32'(tv.gap1));
      check(tv.gap2 > 16'd4 * tv.div ? "R4" : "R5", "gap after byte 2",
            32'(stamp[base + 16] - stamp[base + 15]), 32'(tv.gap2));
      check("R3", "in-byte rise spacing",
            32'(stamp[base + 1] - stamp[base]), 32'(2 * int'(tv.div)));
      seen = '0;
      for (int j = 0; j < 8; j++) seen = {seen[6:0], bitv[base + j]};
      check("R2", "MSB-first bits on MOSI", 32'(seen), 32'(sent[0]));
      check(tv.dma ? "R6" : "R7", "final count", 32'(len_count), 32'(tv.fin_len));
      check("R6", "done flag", 32'(xfer_done), 32'(tv.fin_done));
      check("R6", "cs_n after bytes", 32'(spi_cs_n), 32'(tv.fin_done));
      if (!tv.fin_done) begin
        write_len(16'hAAAA);
        @(negedge clk);
        check("R8", "count write ignored while active", 32'(len_count), 32'(tv.fin_len));
      end
      cfg_enable = 1'b0;
      repeat (3) @(negedge clk);
      check("R11", "cs_n released on disable", 32'(spi_cs_n), 32'd1);
      for (int k = 0; k < 3; k++) pop_rx(sent[k], "R12");
    end

    // Dry transmit queue holds SCLK low with chip select asserted (R9).
    begin
      int base;
      cfg_dma_en = 1'b0; cfg_div = 8'd2;
      write_len(16'd4);
      base = rise_total;
      push_tx(8'hC3);
      cfg_enable = 1'b1;
      wait_rises(base + 8);
      repeat (40) @(negedge clk);
      check("R9", "no edges while dry", 32'(rise_total - base), 32'd8);
      check("R9", "cs_n held while dry", 32'(spi_cs_n), 32'd0);
      check("R9", "sclk low while dry", 32'(spi_sclk), 32'd0);
      push_tx(8'h18);
      repeat (60) @(negedge clk);
      check("R9", "resumes on new data", 32'(rise_total - base), 32'd16);
      pop_rx(8'hC3, "R10");
      pop_rx(8'h18, "R10");
      cfg_enable = 1'b0;
      repeat (3) @(negedge clk);
    end

    // Full queues: transmit back-pressure (R9) and receive stall (R10).
    begin
      int base;
      cfg_div = 8'd1;
      write_len(16'd4);
      base = rise_total;
      for (int k = 0; k < 4; k++) push_tx(8'(8'h40 + k));
      @(negedge clk);
      check("R9", "tx_ready low when full", 32'(tx_ready), 32'd0);
      cfg_enable = 1'b1;
      wait_rises(base + 32);
      repeat (10) @(negedge clk);
      push_tx(8'h44);
      repeat (40) @(negedge clk);
      check("R10", "stall while rx full", 32'(rise_total - base), 32'd32);
      check("R10", "cs_n held during stall", 32'(spi_cs_n), 32'd0);
      pop_rx(8'h40, "R10");
      repeat (40) @(negedge clk);
      check("R10", "resumes after pop", 32'(rise_total - base), 32'd40);
      for (int k = 1; k < 5; k++) pop_rx(8'(8'h40 + k), "R10");
      cfg_enable = 1'b0;
      repeat (3) @(negedge clk);
    end

    // Divider value 0 selects the longest half-period (R3).
    begin
      int base;
      cfg_div = 8'd0;
      write_len(16'd2);
      base = rise_total;
      push_tx(8'hA5);
      cfg_enable = 1'b1;
      wait_rises(base + 2);
      check("R3", "divider 0 spacing", 32'(stamp[base + 1] - stamp[base]), 32'd512);
      wait_rises(base + 8);
      repeat (600) @(negedge clk);
      pop_rx(8'hA5, "R3");
      cfg_enable = 1'b0;
      repeat (3) @(negedge clk);
    end

    // DMA with a zero count completes at once with no edges (R6).
    begin
      int base;
      cfg_div = 8'd2; cfg_dma_en = 1'b1;
      write_len(16'd0);
      base = rise_total;
      cfg_enable = 1'b1;
      repeat (10) @(negedge clk);
      check("R6", "zero count done", 32'(xfer_done), 32'd1);
      check("R6", "zero count cs_n", 32'(spi_cs_n), 32'd1);
      check("R6", "zero count edges", 32'(rise_total - base), 32'd0);
      cfg_enable = 1'b0;
      repeat (3) @(negedge clk);
      check("R6", "done clears on disable", 32'(xfer_done), 32'd0);
    end

    finish_run();
  end
endmodule